// File: doc/BRIEF.md
# Shared Interrupt Line Assertion Counter

This block lets several interrupt sources share each of 32 input lines. It does not hold one level bit per line. It keeps a signed-free count of outstanding asserts: each source that raises the line adds one, and each source that drops it takes one away. A line counts as active while its count is above zero. Commands arrive one per cycle over a valid/ready handshake. Each command carries an operation (raise, drop or pulse) and a line number. Every accepted command returns a 2-bit result code.

The count saturates at both ends, and each kind of saturation has its own result code and its own running total. A delivery request leaves the block only when a line's count goes from zero to one. An interrupt router downstream turns that request into a message. A pulse is a raise followed by a drop as one indivisible command. It takes two internal cycles, and the handshake stalls for the second one.

Top module: `pin_assert_counter`

## Requirements
- R1: A raise (`cmd_op`=0) adds one to the line's 8-bit count. At 255 the count stays at 255, the result code is 1 (saturated high) and `sat_hi_total` increases by one.
- R2: A drop (`cmd_op`=1) takes one from the count. At 0 the count stays 0, the result code is 2 (saturated low) and `sat_lo_total` increases by one.
- R3: `dlv_valid` pulses for one cycle, with `dlv_pin` naming the line, only when a step moves a count from exactly 0 to exactly 1.
- R4: A step that moves a count from 1 to 0 raises no delivery request.
- R5: A pulse (`cmd_op`=2) raises the line and then drops it, so the count ends where it started. It delivers if the count started at 0. `cmd_ready` is low for the one cycle between the two steps, and result code 0 appears two cycles after acceptance.
- R6: A pulse on a line whose count is 255 performs no drop. It returns code 1 one cycle after acceptance, increases `sat_hi_total`, and does not lower `cmd_ready`.
- R7: A line number of 32 or more, or operation code 3, returns code 3. It changes no count, no total and raises no delivery.
- R8: `pin_active[i]` is 1 exactly when line i's count is above zero.
- R9: After reset all counts and both totals are zero, `cmd_ready` is 1, and `rsp_valid` and `dlv_valid` are 0.
- R10: Every accepted command gives exactly one `rsp_valid` pulse. For a raise, a drop or a rejected command, that pulse comes one cycle after acceptance.
- R11: A command changes only the count of the line it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 2 | 0 raise, 1 drop, 2 pulse, 3 reserved |
| cmd_pin | input | 6 | Line number; 32 and above are invalid |
| rsp_valid | output | 1 | Result code valid |
| rsp_code | output | 2 | 0 ok, 1 saturated high, 2 saturated low, 3 invalid |
| dlv_valid | output | 1 | Delivery request for a line that became active |
| dlv_pin | output | 5 | Line of the delivery request |
| pin_active | output | 32 | Per-line count above zero |
| sat_hi_total | output | 16 | Running total of high saturations |
| sat_lo_total | output | 16 | Running total of low saturations |

## Verification
A raise, a drop or a rejected command updates the count, the totals, `pin_active`, `rsp_valid` and `dlv_valid` at the first clock edge after acceptance. A pulse shows its delivery and the stalled `cmd_ready` after the first edge, and its result only after the second. The bench drives and samples on the falling edge. It records the edge count at which the result arrives, whether a delivery was seen and whether ready went low, and it compares that latency against 1 or 2 as the requirement states. Saturation is reached by 255 real raises. It is then confirmed by counting exactly 255 drops back to inactive.

// File: rtl/pinctr_pkg.sv
package pinctr_pkg;

    typedef enum logic [1:0] {
        OP_RAISE = 2'd0,
        OP_DROP  = 2'd1,
        OP_PULSE = 2'd2,
        OP_RSVD  = 2'd3
    } pc_op_e;

    typedef enum logic [1:0] {
        RC_OK     = 2'd0,
        RC_SAT_HI = 2'd1,
        RC_SAT_LO = 2'd2,
        RC_BADARG = 2'd3
    } pc_code_e;

    typedef struct packed {
        pc_code_e code;
        logic     write;
    } step_res_t;

    // Decide the outcome of one unit step on a count.
    function automatic step_res_t step_eval(input logic up, input logic at_zero,
                                            input logic at_max);
        step_res_t r;
        if (up) begin
            r.code  = at_max ? RC_SAT_HI : RC_OK;
            r.write = !at_max;
        end else begin
            r.code  = at_zero ? RC_SAT_LO : RC_OK;
            r.write = !at_zero;
        end
        return r;
    endfunction

endpackage

// File: rtl/pc_count_bank.sv
module pc_count_bank #(
    parameter int PINS  = 32,
    parameter int CW    = 8,
    localparam int IDXW = $clog2(PINS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDXW-1:0]          wr_idx,
    input  logic [CW-1:0]            wr_val,
    output logic [PINS-1:0][CW-1:0]  cnt,
    output logic [PINS-1:0]          active
);

    for (genvar g = 0; g < PINS; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                cnt[g] <= '0;
            else if (wr_en && (wr_idx == IDXW'(g)))
                cnt[g] <= wr_val;
        end

        assign active[g] = (cnt[g] != '0);

        // R1 / R2: a count never moves by more than one per cycle
        assert_unit_step_R1: assert property (@(posedge clk) disable iff (rst)
            (cnt[g] == $past(cnt[g])) ||
            (cnt[g] == $past(cnt[g]) + CW'(1)) ||
            (cnt[g] == $past(cnt[g]) - CW'(1)));
    end

endmodule

// File: rtl/pc_stat_counter.sv
module pc_stat_counter #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [SW-1:0] total
);

    always_ff @(posedge clk) begin
        if (rst)
            total <= '0;
        else if (inc)
            total <= total + SW'(1);
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pinctr_pkg::*;
#(
    parameter int PINS  = 32,
    parameter int CW    = 8,
    parameter int PW    = 6,
    localparam int IDXW = $clog2(PINS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [1:0]               cmd_op,
    input  logic [PW-1:0]            cmd_pin,
    input  logic [PINS-1:0][CW-1:0]  cnt,
    output logic                     wr_en,
    output logic [IDXW-1:0]          wr_idx,
    output logic [CW-1:0]            wr_val,
    output logic                     rsp_valid,
    output logic [1:0]               rsp_code,
    output logic                     dlv_valid,
    output logic [IDXW-1:0]          dlv_pin,
    output logic                     sat_hi_inc,
    output logic                     sat_lo_inc
);

    logic            in_pulse;
    logic [IDXW-1:0] hold_idx;

    logic            fire, pin_ok, op_ok, act_step, step_up;
    logic            at_zero, at_max, deliver, go_pulse, rsp_now;
    logic [IDXW-1:0] step_idx;
    logic [CW-1:0]   cur;
    pc_op_e          op;
    step_res_t       res;
    pc_code_e        code_now;

    assign cmd_ready = !in_pulse;
    assign fire      = cmd_valid && !in_pulse;
    assign op        = pc_op_e'(cmd_op);
    assign pin_ok    = ({1'b0, cmd_pin} < (PW+1)'(PINS));
    assign op_ok     = (op != OP_RSVD);

    always_comb begin
        act_step = in_pulse || (fire && pin_ok && op_ok);
        step_up  = !in_pulse && (op == OP_RAISE || op == OP_PULSE);
        step_idx = in_pulse ? hold_idx : cmd_pin[IDXW-1:0];
        cur      = cnt[step_idx];
        at_zero  = (cur == '0);
        at_max   = (cur == '1);
        res      = step_eval(step_up, at_zero, at_max);
        wr_en    = act_step && res.write;
        wr_idx   = step_idx;
        wr_val   = step_up ? cur + CW'(1) : cur - CW'(1);
        deliver  = act_step && step_up && at_zero;
        sat_hi_inc = act_step && (res.code == RC_SAT_HI);
        sat_lo_inc = act_step && (res.code == RC_SAT_LO);
        go_pulse = fire && pin_ok && (op == OP_PULSE) && (res.code == RC_OK);
        rsp_now  = in_pulse || (fire && !go_pulse);
        code_now = (!in_pulse && !(pin_ok && op_ok)) ? RC_BADARG : res.code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pulse  <= 1'b0;
            hold_idx  <= '0;
            rsp_valid <= 1'b0;
            rsp_code  <= RC_OK;
            dlv_valid <= 1'b0;
            dlv_pin   <= '0;
        end else begin
            in_pulse  <= go_pulse;
            if (go_pulse)
                hold_idx <= step_idx;
            rsp_valid <= rsp_now;
            rsp_code  <= rsp_now ? code_now : RC_OK;
            dlv_valid <= deliver;
            dlv_pin   <= deliver ? step_idx : '0;
        end
    end

    // R5 / R6: an accepted pulse either stalls ready or answers at once
    assert_pulse_stall_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op == 2'(OP_PULSE)) |=> (!cmd_ready || rsp_valid));

    // R5: the stall lasts exactly one cycle and ends with the result
    assert_stall_once_R5: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |=> (cmd_ready && rsp_valid));

    // R10: non-pulse commands answer on the next cycle
    assert_rsp_next_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op != 2'(OP_PULSE)) |=> rsp_valid);

endmodule

// File: rtl/pin_assert_counter.sv
module pin_assert_counter #(
    parameter int PINS   = 32,
    parameter int CNT_W  = 8,
    parameter int PIN_W  = 6,
    parameter int STAT_W = 16,
    localparam int IDXW  = $clog2(PINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [PIN_W-1:0]  cmd_pin,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              dlv_valid,
    output logic [IDXW-1:0]   dlv_pin,
    output logic [PINS-1:0]   pin_active,
    output logic [STAT_W-1:0] sat_hi_total,
    output logic [STAT_W-1:0] sat_lo_total
);

    logic [PINS-1:0][CNT_W-1:0] cnt;
    logic                       wr_en, sat_hi_inc, sat_lo_inc;
    logic [IDXW-1:0]            wr_idx;
    logic [CNT_W-1:0]           wr_val;

    pc_sequencer #(.PINS(PINS), .CW(CNT_W), .PW(PIN_W)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_pin(cmd_pin),
        .cnt(cnt),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .dlv_valid(dlv_valid), .dlv_pin(dlv_pin),
        .sat_hi_inc(sat_hi_inc), .sat_lo_inc(sat_lo_inc)
    );

    pc_count_bank #(.PINS(PINS), .CW(CNT_W)) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .cnt(cnt), .active(pin_active)
    );

    pc_stat_counter #(.SW(STAT_W)) u_hi (
        .clk(clk), .rst(rst), .inc(sat_hi_inc), .total(sat_hi_total)
    );

    pc_stat_counter #(.SW(STAT_W)) u_lo (
        .clk(clk), .rst(rst), .inc(sat_lo_inc), .total(sat_lo_total)
    );

    // R3: a delivered line is active in the cycle the request appears
    assert_dlv_active_R3: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> pin_active[dlv_pin]);

    // R7: an out-of-range line leaves every line and delivery untouched
    assert_badpin_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && ({1'b0, cmd_pin} >= (PIN_W+1)'(PINS)))
        |=> ($stable(pin_active) && !dlv_valid));

    // R1: a high-saturation result comes with a moved total
    assert_hi_total_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 2'd1) |-> (sat_hi_total != $past(sat_hi_total)));

    // R2: a low-saturation result comes with a moved total
    assert_lo_total_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == 2'd2) |-> (sat_lo_total != $past(sat_lo_total)));

endmodule

// File: tb/pin_assert_counter_test.sv
module pin_assert_counter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [5:0]  cmd_pin = 6'd0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic        dlv_valid;
    logic [4:0]  dlv_pin;
    logic [31:0] pin_active;
    logic [15:0] sat_hi_total, sat_lo_total;

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    pin_assert_counter uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_pin(cmd_pin),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .dlv_valid(dlv_valid), .dlv_pin(dlv_pin),
        .pin_active(pin_active),
        .sat_hi_total(sat_hi_total), .sat_lo_total(sat_lo_total)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 60000 && !done) begin
            nerr++;
            $display("FAIL watchdog: actual=%0d expected=<60000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one command, then watch up to four edges for its result.
    task automatic issue(input logic [1:0] op, input logic [5:0] pin,
                         output int code, output int lat, output bit dlv,
                         output int dpin, output bit rdy_low);
        code = -1; lat = 0; dlv = 0; dpin = -1; rdy_low = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_pin = pin;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k == 1) cmd_valid = 1'b0;
            if (dlv_valid) begin dlv = 1; dpin = int'(dlv_pin); end
            if (!cmd_ready) rdy_low = 1;
            if (rsp_valid) begin code = int'(rsp_code); lat = k; break; end
        end
    endtask

    task automatic t_reset();
        chk("R9", "ready", cmd_ready, 1);
        chk("R9", "rsp_valid", rsp_valid, 0);
        chk("R9", "dlv_valid", dlv_valid, 0);
        chk("R9", "active", pin_active, 0);
        chk("R9", "hi total", sat_hi_total, 0);
        chk("R9", "lo total", sat_lo_total, 0);
    endtask

    task automatic t_raise_drop();
        int c, l, dp; bit d, r;
        issue(2'd0, 6'd5, c, l, d, dp, r);
        chk("R10", "raise latency", l, 1);
        chk("R1", "raise code", c, 0);
        chk("R3", "first raise delivers", d, 1);
        chk("R3", "delivery line", dp, 5);
        chk("R8", "active after raise", pin_active, 32'h20);
        issue(2'd0, 6'd5, c, l, d, dp, r);
        chk("R3", "second raise no delivery", d, 0);
        issue(2'd1, 6'd5, c, l, d, dp, r);
        chk("R2", "drop code", c, 0);
        chk("R8", "still active at count 1", pin_active[5], 1);
        issue(2'd1, 6'd5, c, l, d, dp, r);
        chk("R4", "1->0 no delivery", d, 0);
        chk("R8", "inactive at 0", pin_active, 0);
    endtask

    task automatic t_underflow();
        int c, l, dp; bit d, r;
        issue(2'd1, 6'd7, c, l, d, dp, r);
        chk("R2", "underflow code", c, 2);
        chk("R2", "lo total", sat_lo_total, 1);
        chk("R2", "count stays zero", pin_active, 0);
        issue(2'd0, 6'd7, c, l, d, dp, r);
        chk("R2", "raise after underflow delivers", d, 1);
        issue(2'd1, 6'd7, c, l, d, dp, r);
        chk("R2", "back to zero", pin_active, 0);
    endtask

    task automatic t_pulse();
        int c, l, dp; bit d, r;
        issue(2'd2, 6'd9, c, l, d, dp, r);
        chk("R5", "pulse latency", l, 2);
        chk("R5", "pulse code", c, 0);
        chk("R5", "ready stalled", r, 1);
        chk("R5", "pulse from 0 delivers", d, 1);
        chk("R5", "pulse delivery line", dp, 9);
        chk("R5", "count restored", pin_active, 0);
        issue(2'd0, 6'd9, c, l, d, dp, r);
        issue(2'd2, 6'd9, c, l, d, dp, r);
        chk("R5", "pulse from 1 no delivery", d, 0);
        chk("R5", "still active after pulse", pin_active, 32'h200);
        issue(2'd1, 6'd9, c, l, d, dp, r);
    endtask

    task automatic t_saturate();
        int c, l, dp, ndlv, nbad; bit d, r;
        ndlv = 0; nbad = 0;
        for (int i = 0; i < 255; i++) begin
            issue(2'd0, 6'd3, c, l, d, dp, r);
            if (d) ndlv++;
            if (c != 0) nbad++;
        end
        chk("R1", "255 raises all ok", nbad, 0);
        chk("R3", "one delivery in 255 raises", ndlv, 1);
        issue(2'd0, 6'd3, c, l, d, dp, r);
        chk("R1", "raise at max code", c, 1);
        chk("R1", "hi total", sat_hi_total, 1);
        issue(2'd2, 6'd3, c, l, d, dp, r);
        chk("R6", "pulse at max code", c, 1);
        chk("R6", "pulse at max latency", l, 1);
        chk("R6", "no ready stall", r, 0);
        chk("R6", "hi total", sat_hi_total, 2);
        for (int i = 0; i < 254; i++) issue(2'd1, 6'd3, c, l, d, dp, r);
        chk("R1", "active after 254 drops", pin_active[3], 1);
        issue(2'd1, 6'd3, c, l, d, dp, r);
        chk("R1", "inactive after 255 drops", pin_active[3], 0);
        chk("R2", "no low saturation on the way", sat_lo_total, 1);
    endtask

    task automatic t_invalid();
        int c, l, dp; bit d, r;
        issue(2'd0, 6'd40, c, l, d, dp, r);
        chk("R7", "bad line code", c, 3);
        chk("R10", "bad line latency", l, 1);
        chk("R7", "bad line no delivery", d, 0);
        chk("R7", "bad line no change", pin_active, 0);
        issue(2'd3, 6'd2, c, l, d, dp, r);
        chk("R7", "reserved op code", c, 3);
        chk("R7", "reserved op no change", pin_active, 0);
        issue(2'd2, 6'd33, c, l, d, dp, r);
        chk("R7", "bad pulse code", c, 3);
        chk("R7", "bad pulse no stall", r, 0);
        issue(2'd1, 6'd32, c, l, d, dp, r);
        chk("R7", "bad drop totals", sat_lo_total, 1);
    endtask

    task automatic t_independent();
        int c, l, dp; bit d, r;
        issue(2'd0, 6'd0, c, l, d, dp, r);
        issue(2'd0, 6'd31, c, l, d, dp, r);
        chk("R11", "delivery line 31", dp, 31);
        chk("R11", "two lines active", pin_active, 32'h8000_0001);
        issue(2'd1, 6'd0, c, l, d, dp, r);
        chk("R11", "only line 0 dropped", pin_active, 32'h8000_0000);
        issue(2'd1, 6'd31, c, l, d, dp, r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_raise_drop();
        t_underflow();
        t_pulse();
        t_saturate();
        t_invalid();
        t_independent();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule